// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the slave side of a host bus that reaches a bank of four 16-bit control and status registers through indirect addressing. The bus has two ports. An index port holds the number of the register to reach. A data port reads or writes whichever register that index names. One select input chooses the port for each transaction. The host normally writes the index once and then makes as many data transfers as it needs to that register.

Register 0 is always reachable. Bit 2 of register 0 is a stop flag, and registers 1 to 3 are open only while that flag is set. When the flag is clear, an access to those three registers still completes with a ready pulse, but the access does nothing: a write is dropped and a read returns zero. The flag is set at reset, so software can program the upper registers right after start-up. Software clears the flag by writing register 0.

Top module: `csr_indirect_port`

## Requirements
- R1: After reset, ready and rdata are zero, the index is 0, register 0 holds 0x0004 (stop flag set), and registers 1 to 3 hold zero.
- R2: A strobe with sel_addr=1 and wr=1 loads wdata[1:0] into the index. Bits 15:2 of wdata are ignored.
- R3: A strobe with sel_addr=1 and wr=0 returns the index in rdata[1:0], with bits 15:2 zero.
- R4: A strobe with sel_addr=0 and wr=1 stores wdata in the indexed register, provided that register is open. A strobe with sel_addr=0 and wr=0 returns that register's value.
- R5: The index changes only on an index-port write, so any number of data-port accesses reach the same register.
- R6: Register 0 can be read and written whatever the value of the stop flag. The stop flag is bit 2 of register 0.
- R7: While the stop flag is clear, a data-port write to registers 1 to 3 leaves all three registers unchanged, and ready is still asserted.
- R8: While the stop flag is clear, a data-port read of registers 1 to 3 returns zero, and ready is still asserted.
- R9: ready is high for exactly the one cycle after each strobe, for reads and for writes. Back-to-back strobes give back-to-back ready cycles.
- R10: With cs low, the index and the registers keep their values, and in the next cycle ready is low and rdata is zero. rdata is also zero in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised to clk |
| cs | input | 1 | Single-cycle transaction strobe |
| sel_addr | input | 1 | 1 selects the index port, 0 selects the data port |
| wr | input | 1 | 1 for a write, 0 for a read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle where ready is high |
| ready | output | 1 | Completion pulse, one cycle after the strobe |

## Verification
A corrupted index shows up at the first index-port read, one cycle after the strobe. It also shows up at the first data-port read, because that read returns another register's contents. A stop gate that fails open or closed shows up in one of two ways. A read of a gated register returns a nonzero value, or a register written while gated keeps the write, and this becomes visible when the stop flag is set again and the register is read back. The bench model predicts ready and rdata for every cycle, so a single-cycle error in the ready timing is reported in the cycle it happens.

// File: rtl/csr_port_pkg.sv
package csr_port_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_IDX_WR,
    ACC_IDX_RD,
    ACC_DAT_WR,
    ACC_DAT_RD
  } acc_e;

  function automatic acc_e acc_decode(input logic cs, input logic sel_addr, input logic wr);
    if (!cs)          return ACC_IDLE;
    else if (sel_addr) return wr ? ACC_IDX_WR : ACC_IDX_RD;
    else               return wr ? ACC_DAT_WR : ACC_DAT_RD;
  endfunction

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/csr_index_reg.sv
module csr_index_reg #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (load) idx_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end

endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int STOP_BIT = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rd_value,
  output logic                       stop,
  output logic [NUM_REGS*DATA_W-1:0] flat
);

  logic open_sel;

  // Register 0 holds the stop flag that gates the others.
  assign stop     = flat[STOP_BIT];
  assign open_sel = (idx == '0) || stop;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? (DATA_W'(1) << STOP_BIT) : '0;
    logic              en;
    logic [DATA_W-1:0] q_r;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = wr_en && (idx == IDX_W'(g)) && open_sel;
      d  = en ? wdata : q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_VAL;
      else if (en) q_r <= d;
    end

    assign flat[g*DATA_W +: DATA_W] = q_r;
  end

  always_comb begin
    rd_value = '0;
    if (open_sel) rd_value = flat[idx*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/csr_indirect_port.sv
module csr_indirect_port #(
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 4,
  parameter int STOP_BIT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sel_addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  import csr_port_pkg::*;

  localparam int IDX_W = $clog2(NUM_REGS);

  logic                       rst_sync_n;
  acc_e                       acc;
  logic [IDX_W-1:0]           idx_q;
  logic [DATA_W-1:0]          bank_rd;
  logic                       stop_bit;
  logic [NUM_REGS*DATA_W-1:0] bank_flat;
  logic [DATA_W-1:0]          rdata_d;
  logic                       ready_d;

  csr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign acc = acc_decode(cs, sel_addr, wr);

  csr_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (acc == ACC_IDX_WR),
    .din   (wdata[IDX_W-1:0]),
    .idx   (idx_q)
  );

  csr_reg_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .STOP_BIT (STOP_BIT)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (acc == ACC_DAT_WR),
    .idx      (idx_q),
    .wdata    (wdata),
    .rd_value (bank_rd),
    .stop     (stop_bit),
    .flat     (bank_flat)
  );

  always_comb begin
    ready_d = (acc != ACC_IDLE);
    case (acc)
      ACC_IDX_RD: rdata_d = DATA_W'(idx_q);
      ACC_DAT_RD: rdata_d = bank_rd;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ready <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= ready_d;
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/csr_indirect_port_chk.sv
module csr_indirect_port_chk #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs,
  input logic                       sel_addr,
  input logic                       wr,
  input logic [DATA_W-1:0]          wdata,
  input logic [DATA_W-1:0]          rdata,
  input logic                       ready,
  input logic [IDX_W-1:0]           idx,
  input logic                       stop,
  input logic [NUM_REGS*DATA_W-1:0] bank
);

  assert_ready_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs |=> ready);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (!ready && rdata == '0));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sel_addr && wr) |=> (idx == $past(wdata[IDX_W-1:0])));

  assert_index_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && sel_addr && wr) |=> $stable(idx));

  assert_index_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sel_addr && !wr) |=> (rdata == DATA_W'($past(idx))));

  assert_gated_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !sel_addr && wr && idx != '0 && !stop) |=> $stable(bank[NUM_REGS*DATA_W-1:DATA_W]));

  assert_gated_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !sel_addr && !wr && idx != '0 && !stop) |=> (rdata == '0));

endmodule

bind csr_indirect_port csr_indirect_port_chk #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cs       (cs),
  .sel_addr (sel_addr),
  .wr       (wr),
  .wdata    (wdata),
  .rdata    (rdata),
  .ready    (ready),
  .idx      (idx_q),
  .stop     (stop_bit),
  .bank     (bank_flat)
);

// File: tb/csr_indirect_port_test.sv
module csr_indirect_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        sel_addr = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ready;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_indirect_port uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sel_addr(sel_addr),
    .wr(wr), .wdata(wdata), .rdata(rdata), .ready(ready)
  );

  // Behavioural reference
  logic [15:0] m_regs [4];
  int          m_idx;
  logic        m_ready;
  logic [15:0] m_rdata;
  int          m_sync;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || m_sync < 2) begin
      if (!rst_n) m_sync = 0; else m_sync = m_sync + 1;
      m_regs[0] = 16'h0004; m_regs[1] = '0; m_regs[2] = '0; m_regs[3] = '0;
      m_idx = 0; m_ready = 1'b0; m_rdata = '0;
    end else begin
      bit open;
      open = (m_idx == 0) || m_regs[0][2];
      m_ready = cs;
      m_rdata = '0;
      if (cs) begin
        if (sel_addr) begin
          if (wr) m_idx = int'(wdata[1:0]);
          else    m_rdata = 16'(m_idx);
        end else begin
          if (wr) begin
            if (open) m_regs[m_idx] = wdata;
          end else begin
            m_rdata = open ? m_regs[m_idx] : 16'h0000;
          end
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_req, "ready", 16'(ready), 16'(m_ready));
      chk(cur_req, "rdata", rdata, m_rdata);
    end
  end

  task automatic acc(bit sel, bit w, logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; sel_addr = sel; wr = w; wdata = d;
  endtask

  // cs low with noise on the other inputs
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs = 1'b0; sel_addr = i[0]; wr = i[1]; wdata = 16'hDEAD ^ 16'(i);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(5);
    acc(1, 0, 0);             // R1 index reads 0
    acc(0, 0, 0);             // R1 reg0 = 0004
    idle(1);
    cur_req = "R2"; acc(1, 1, 16'hFFF1);  // only low two bits taken
    cur_req = "R3"; acc(1, 0, 0);
    idle(2);
    cur_req = "R4";
    acc(0, 1, 16'hA5A5); acc(0, 0, 0);
    acc(1, 1, 16'h0002); acc(0, 1, 16'h1234);
    acc(1, 1, 16'h0003); acc(0, 1, 16'hBEEF);
    acc(1, 1, 16'h0002); acc(0, 0, 0);
    acc(1, 1, 16'h0001); acc(0, 0, 0);
    idle(1);
    cur_req = "R5"; acc(1, 1, 16'h0003);
    idle(2);
    acc(0, 0, 0); acc(0, 0, 0); acc(0, 1, 16'h7777); acc(0, 0, 0);
    cur_req = "R9"; acc(1, 0, 0); acc(0, 0, 0); idle(1); acc(0, 0, 0); idle(2);
    cur_req = "R6"; acc(1, 1, 16'h0000); acc(0, 1, 16'h00F0); acc(0, 0, 0);
    cur_req = "R7"; acc(1, 1, 16'h0001); acc(0, 1, 16'h5555);
    acc(1, 1, 16'h0003); acc(0, 1, 16'h6666);
    cur_req = "R8"; acc(0, 0, 0); acc(1, 1, 16'h0002); acc(0, 0, 0);
    cur_req = "R6"; acc(1, 1, 16'h0000); acc(0, 0, 0); acc(0, 1, 16'h0004);
    cur_req = "R7"; acc(1, 1, 16'h0001); acc(0, 0, 0);
    acc(1, 1, 16'h0003); acc(0, 0, 0);
    cur_req = "R10"; idle(6);
    acc(0, 0, 0); acc(0, 1, 16'h0101); idle(1);
    acc(1, 0, 0); idle(2);
    cur_req = "R1"; rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(4);
    acc(1, 0, 0); acc(0, 0, 0); acc(1, 1, 16'h0003); acc(0, 0, 0);
    idle(3);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule